// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

The block is an 8-bit up-counter that advances on a tick taken from the system clock through one of eight fixed divisors. When the counter wraps from 0xFF to 0x00 it either raises an interval interrupt and keeps counting, or it acts as a watchdog. As a watchdog it drives a stretched overflow output and, if allowed, a stretched internal reset request.

Software reaches three registers through a small register bus: a timer control register, a read-only count, and a reset status register. Both writable registers accept a write only when the upper byte of the 16-bit write word carries that register's key. The reset status register keeps its contents through the internal reset that the watchdog itself raises. Only the external reset or the standby input returns it to 0x1F.

Top module: `wdog_timer`

## Requirements
- R1: After external reset the control register reads 0x18, the count reads 0x00, the reset status register reads 0x1F, and ovf_o, rst_req_o, rst_kind_o and irq_o are low.
- R2: A write changes the control register (address 0) only if bus_wdata[15:8] is 0xA5. It changes the reset status register (address 2) only if bus_wdata[15:8] is 0x5A. Any other write, including any write to address 1 or 3, leaves all state unchanged.
- R3: Control register bits 4:3 always read 1, whatever value is written to them.
- R4: Control bit 5 is the run bit. While it is 0 the count is forced to 0x00 from the cycle after the write and stays there. After a write that sets it, the first increment lands exactly one divisor period after the write edge.
- R5: Control bits 2:0 select the tick divisor: codes 0 to 7 give 2, 64, 128, 256, 512, 1024, 4096 and 8192 system clocks per count. The reset code is 0.
- R6: The count wraps to 0x00 on the 256th tick after it started at 0x00. On that same edge control bit 7 (the overflow flag) is set.
- R7: Control bit 6 selects the mode (0 = interval, 1 = watchdog). In interval mode irq_o equals the overflow flag and counting continues after the wrap. ovf_o and rst_req_o stay low.
- R8: Control bit 7 is cleared only by a keyed control write with bit 7 = 0 that follows a read of the control register (bus_rd at address 0) which returned the flag as 1. Without that read, the write leaves the flag set.
- R9: In watchdog mode an overflow sets reset status bit 7. It also drives ovf_o high for exactly OVF_HOLD (512) cycles, starting at the overflow edge.
- R10: Reset status bit 6 enables the internal reset and bit 5 selects its kind. With bit 6 set, a watchdog overflow drives rst_req_o high for exactly RST_HOLD (128) cycles, with rst_kind_o showing bit 5 while the request is active. On the same edge the control register returns to 0x18 and the count to 0. The reset status register is not cleared.
- R11: A cycle with standby high returns the reset status register to 0x1F and the control register to 0x18. It also clears the count and drops ovf_o and rst_req_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, synchronous, active low |
| standby | input | 1 | Standby entry; re-initialises the registers |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 reset status |
| bus_wdata | input | 16 | Write word: key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ovf_o | output | 1 | Stretched watchdog overflow output |
| rst_req_o | output | 1 | Stretched internal reset request |
| rst_kind_o | output | 1 | Reset kind, valid while rst_req_o is high |
| irq_o | output | 1 | Interval interrupt |

## Verification
Register writes take effect on the write edge, and the count follows the run bit one edge later. The first count then lands a full divisor period after the enabling write, and the wrap lands on edge 256 x divisor. The bench counts edges from each write and reads the combinational read port one nanosecond after the falling edge, so every sample falls between the edge that should change a value and the next one. The two stretched outputs are sampled on their last high cycle and on their first low cycle.

// File: rtl/wdog_pkg.sv
// Shared constants, register layouts and the divisor table of the watchdog.
// Assumes an 8-bit register file and a 16-bit keyed write word.
package wdog_pkg;
    localparam int REG_W = 8;
    localparam int CNT_W = 8;
    localparam int KEY_W = 8;
    localparam int BUS_W = KEY_W + REG_W;
    localparam int SEL_W = 3;
    localparam int PRE_W = 13;

    // Control register layout as stored (reserved bits are not stored)
    typedef struct packed {
        logic             flag;
        logic             mode;
        logic             run;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    // Reset status register layout as stored (low five bits read as 1)
    typedef struct packed {
        logic wd_flag;
        logic rst_en;
        logic rst_kind;
    } rsts_t;

    localparam ctrl_t CTRL_INIT = '0;
    localparam rsts_t RSTS_INIT = '0;

    // Terminal prescaler value (divisor minus one) for each select code
    function automatic logic [PRE_W-1:0] div_last(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    div_last = PRE_W'(1);
            3'd1:    div_last = PRE_W'(63);
            3'd2:    div_last = PRE_W'(127);
            3'd3:    div_last = PRE_W'(255);
            3'd4:    div_last = PRE_W'(511);
            3'd5:    div_last = PRE_W'(1023);
            3'd6:    div_last = PRE_W'(4095);
            default: div_last = PRE_W'(8191);
        endcase
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
// Divides the system clock down to a one-cycle count tick.
// Assumes the select may change while running; a count already past
// the new terminal value ticks at once and restarts from zero.
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q >= div_last(sel));

    // Free-running divider, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_stretch.sv
// Stretches a one-cycle event to exactly HOLD cycles, starting on the
// edge of the event. A new event reloads the full length.
// Assumes HOLD >= 1.
module wdog_stretch #(
    parameter int HOLD = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fire,
    output logic active
);
    localparam int W = $clog2(HOLD + 1);

    logic [W-1:0] left_q;

    assign active = (left_q != '0);

    // Remaining-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (clr)
            left_q <= '0;
        else if (fire)
            left_q <= W'(HOLD);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/wdog_timer.sv
// Watchdog / interval timer: keyed register bus, prescaled 8-bit count,
// overflow flag, stretched overflow and internal reset outputs.
// Assumes a synchronous active-low external reset and a one-cycle
// standby entry strobe; reads are combinational.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter logic [KEY_W-1:0] CTRL_KEY = 8'hA5,
    parameter logic [KEY_W-1:0] RSTS_KEY = 8'h5A,
    parameter int               OVF_HOLD = 512,
    parameter int               RST_HOLD = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             ovf_o,
    output logic             rst_req_o,
    output logic             rst_kind_o,
    output logic             irq_o
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_RSTS = 2'd2;

    ctrl_t            ctrl_q, ctrl_d;
    rsts_t            rsts_q, rsts_d;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             tick, ovf_evt, wd_evt, int_rst, reinit;
    logic             wr_ctrl, wr_rsts;
    logic [KEY_W-1:0] key;
    logic [REG_W-1:0] wdat;
    logic             unused_bits;

    assign key         = bus_wdata[BUS_W-1:REG_W];
    assign wdat        = bus_wdata[REG_W-1:0];
    assign unused_bits = ^wdat[4:0];
    assign wr_ctrl     = bus_wr && bus_addr == A_CTRL && key == CTRL_KEY;
    assign wr_rsts     = bus_wr && bus_addr == A_RSTS && key == RSTS_KEY;

    wdog_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.run),
        .sel  (ctrl_q.sel),
        .tick (tick)
    );

    assign ovf_evt = tick && (cnt_q == '1);
    assign wd_evt  = ovf_evt && ctrl_q.mode;
    assign int_rst = wd_evt && rsts_q.rst_en;
    assign reinit  = standby || int_rst;

    // Next control value: keyed field update, flag set beats flag clear
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.mode = wdat[6];
            ctrl_d.run  = wdat[5];
            ctrl_d.sel  = wdat[SEL_W-1:0];
            if (!wdat[7] && armed_q)
                ctrl_d.flag = 1'b0;
        end
        if (ovf_evt)
            ctrl_d.flag = 1'b1;
    end

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n || reinit)
            ctrl_q <= CTRL_INIT;
        else
            ctrl_q <= ctrl_d;
    end

    // Flag-clear arming: a read that saw the flag set
    always_ff @(posedge clk) begin
        if (!rst_n || reinit || wr_ctrl)
            armed_q <= 1'b0;
        else if (bus_rd && bus_addr == A_CTRL && ctrl_q.flag)
            armed_q <= 1'b1;
    end

    // Count register: cleared while stopped, wraps on overflow
    always_ff @(posedge clk) begin
        if (!rst_n || reinit || !ctrl_q.run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Next reset status value
    always_comb begin
        rsts_d = rsts_q;
        if (wr_rsts) begin
            rsts_d.rst_en   = wdat[6];
            rsts_d.rst_kind = wdat[5];
            if (!wdat[7])
                rsts_d.wd_flag = 1'b0;
        end
        if (wd_evt)
            rsts_d.wd_flag = 1'b1;
    end

    // Reset status storage: survives the internal reset
    always_ff @(posedge clk) begin
        if (!rst_n || standby)
            rsts_q <= RSTS_INIT;
        else
            rsts_q <= rsts_d;
    end

    wdog_stretch #(.HOLD(OVF_HOLD)) u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (standby),
        .fire  (wd_evt),
        .active(ovf_o)
    );

    wdog_stretch #(.HOLD(RST_HOLD)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (standby),
        .fire  (int_rst),
        .active(rst_req_o)
    );

    assign rst_kind_o = rst_req_o && rsts_q.rst_kind;
    assign irq_o      = ctrl_q.flag && !ctrl_q.mode;

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {ctrl_q.flag, ctrl_q.mode, ctrl_q.run, 2'b11, ctrl_q.sel};
            A_CNT:   bus_rdata = REG_W'(cnt_q);
            A_RSTS:  bus_rdata = {rsts_q.wd_flag, rsts_q.rst_en, rsts_q.rst_kind, 5'b11111};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_timer_chk.sv
// Property checker for wdog_timer, attached by bind below.
// Assumes it observes the stored register state and overflow event.
module wdog_timer_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic             bus_wr,
    input logic             ovf_evt,
    input ctrl_t            ctrl_q,
    input rsts_t            rsts_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_o,
    input logic             rst_req_o,
    input logic             irq_o
);
    // R4
    cnt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |=> cnt_q == '0);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !standby && !(ctrl_q.mode && rsts_q.rst_en)) |=> (cnt_q == '0 && ctrl_q.flag));

    // R7
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ctrl_q.mode && !standby) |=> irq_o);

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.flag) |-> ($past(bus_wr) || $past(standby) || $rose(rst_req_o)));

    // R9
    ovf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && ctrl_q.mode && !standby) |=> (ovf_o && rsts_q.wd_flag));

    // R10
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && ctrl_q.mode && rsts_q.rst_en && !standby) |=> (rst_req_o && !ctrl_q.run && rsts_q.rst_en));

    // R11
    standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (rsts_q == RSTS_INIT && !ovf_o && !rst_req_o && cnt_q == '0));
endmodule

bind wdog_timer wdog_timer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .bus_wr   (bus_wr),
    .ovf_evt  (ovf_evt),
    .ctrl_q   (ctrl_q),
    .rsts_q   (rsts_q),
    .cnt_q    (cnt_q),
    .ovf_o    (ovf_o),
    .rst_req_o(rst_req_o),
    .irq_o    (irq_o)
);

// File: tb/wdog_timer_tb_top.sv
// Bench for wdog_timer: seeded random keyed writes plus directed
// timing cases; inputs change on the falling edge.
module wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        ovf_o, rst_req_o, rst_kind_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_timer dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_o(ovf_o), .rst_req_o(rst_req_o), .rst_kind_o(rst_kind_o), .irq_o(irq_o)
    );

    function automatic int div_of(input int code);
        int t[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
        return t[code];
    endfunction

    function automatic logic [7:0] ctrl_exp(input bit f, input bit m, input bit r, input logic [2:0] s);
        return {f, m, r, 2'b11, s};
    endfunction

    function automatic logic [7:0] rsts_exp(input bit f, input bit e, input bit k);
        return {f, e, k, 5'b11111};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_arm(input logic [1:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit m_mode, m_en, m_kind;
        logic [2:0] m_sel;
        void'($urandom(32'h1D2C3B4A));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        peek(0, v); chk("R1 ctrl", v, 8'h18);
        peek(1, v); chk("R1 cnt", v, 8'h00);
        peek(2, v); chk("R1 rsts", v, 8'h1F);
        chk("R1 outs", {ovf_o, rst_req_o, rst_kind_o, irq_o}, 4'b0000);

        // R2 R3 random keyed writes, run bit kept 0
        m_mode = 0; m_sel = 0; m_en = 0; m_kind = 0;
        for (int i = 0; i < 200; i++) begin
            logic [1:0] a;
            logic [7:0] k, d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (a == 2'd0) d[5] = 1'b0;
            if ($urandom_range(0, 1) == 1)
                k = (a == 2'd2) ? 8'h5A : 8'hA5;
            else
                k = 8'($urandom);
            wr(a, {k, d});
            if (a == 2'd0 && k == 8'hA5) begin m_mode = d[6]; m_sel = d[2:0]; end
            if (a == 2'd2 && k == 8'h5A) begin m_en = d[6]; m_kind = d[5]; end
            peek(0, v); chk("R2 R3 ctrl", v, ctrl_exp(0, m_mode, 0, m_sel));
            peek(2, v); chk("R2 rsts", v, rsts_exp(0, m_en, m_kind));
            peek(1, v); chk("R2 cnt", v, 8'h00);
        end

        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);

        // R4 R5 R6 R7 interval mode at divide-by-2
        wr(0, 16'hA520);
        step(20);  peek(1, v); chk("R4 first counts", v, 8'd10);
        step(491); peek(1, v); chk("R6 before wrap", v, 8'hFF);
        chk("R6 no irq yet", irq_o, 1'b0);
        step(1);   peek(1, v); chk("R6 wrap", v, 8'h00);
        peek(0, v); chk("R6 flag", v, ctrl_exp(1, 0, 1, 3'd0));
        chk("R7 irq", irq_o, 1'b1);
        chk("R7 no ovf/rst", {ovf_o, rst_req_o}, 2'b00);
        step(2);   peek(1, v); chk("R7 keeps counting", v, 8'd1);

        // R8 flag clear needs prior read
        wr(0, 16'hA520);
        peek(0, v); chk("R8 unarmed clear ignored", v, ctrl_exp(1, 0, 1, 3'd0));
        rd_arm(0);
        wr(0, 16'hA520);
        peek(0, v); chk("R8 armed clear", v, ctrl_exp(0, 0, 1, 3'd0));
        chk("R8 irq low", irq_o, 1'b0);

        // R4 stop
        wr(0, 16'hA500);
        step(1);  peek(1, v); chk("R4 stop clears", v, 8'h00);
        step(10); peek(1, v); chk("R4 stays zero", v, 8'h00);

        // R5 divisor sweep
        for (int c = 0; c < 8; c++) begin
            int dv;
            dv = div_of(c);
            wr(0, 16'hA500); step(1);
            wr(0, 16'hA520 | 16'(c));
            step(3 * dv - 1); peek(1, v); chk("R5 before third tick", v, 8'd2);
            step(1);          peek(1, v); chk("R5 third tick", v, 8'd3);
        end

        // R9 watchdog mode without internal reset
        wr(0, 16'hA500); step(1);
        wr(0, 16'hA560);
        step(512);
        chk("R9 ovf high", ovf_o, 1'b1);
        chk("R9 no rst", rst_req_o, 1'b0);
        peek(2, v); chk("R9 rsts flag", v, rsts_exp(1, 0, 0));
        chk("R9 no irq", irq_o, 1'b0);
        wr(0, 16'hA500);
        step(510); chk("R9 last high cycle", ovf_o, 1'b1);
        step(1);   chk("R9 released", ovf_o, 1'b0);
        wr(2, 16'h5A00);
        peek(2, v); chk("R2 rsts flag clear", v, 8'h1F);

        // R10 watchdog with internal reset
        wr(2, 16'h5A60);
        peek(2, v); chk("R10 rsts set", v, rsts_exp(0, 1, 1));
        wr(0, 16'hA560);
        step(512);
        chk("R10 rst req", {rst_req_o, rst_kind_o, ovf_o}, 3'b111);
        peek(0, v); chk("R10 ctrl reinit", v, 8'h18);
        peek(1, v); chk("R10 cnt reinit", v, 8'h00);
        peek(2, v); chk("R10 rsts kept", v, 8'hFF);
        step(127); chk("R10 last rst cycle", rst_req_o, 1'b1);
        step(1);   chk("R10 rst released", {rst_req_o, rst_kind_o}, 2'b00);
        chk("R10 ovf longer", ovf_o, 1'b1);

        // R11 standby
        standby = 1'b1; step(1); standby = 1'b0;
        peek(2, v); chk("R11 rsts", v, 8'h1F);
        peek(0, v); chk("R11 ctrl", v, 8'h18);
        chk("R11 outs", {ovf_o, rst_req_o}, 2'b00);

        // R2 directed bad keys
        wr(0, 16'h1227);
        peek(0, v); chk("R2 bad key ctrl", v, 8'h18);
        wr(1, 16'hA5FF);
        peek(1, v); chk("R2 cnt not writable", v, 8'h00);
        wr(2, 16'hA560);
        peek(2, v); chk("R2 bad key rsts", v, 8'h1F);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule